// File: doc/BRIEF.md
# Transmit Modulation Source Controller

This block is the digital front end of a small wireless transmitter. It decides where each transmitted modulation bit comes from and tracks whether the transmitter is on. There are four sources: a general-purpose data pin, the serial data-in pin, a packet FIFO, and an internal pseudo-random PN9 generator. A separate field chooses which output pin, if any, carries a data clock that pulses on every bit. Both choices, plus an inversion switch and two fields passed through to the modulator, live in one 8-bit control register.

A bit strobe from the modulator paces the buffered sources. In FIFO mode the block fetches one byte at a time from a show-ahead FIFO and shifts it out MSB first. When the last byte has gone out, it raises a one-cycle packet-sent pulse and clears its own transmit-on bit. The operating state then falls back to tune if the PLL-on bit is set, and to idle if it is not. The pin sources bypass all storage and pass straight through in the same cycle.

Top module: `tx_mod_source`

## Requirements
- R1: After reset the control register reads 0x23, transmit-on and PLL-on are 0, the operating state is idle (0), and txData, all clock pins, fifoRdEn and pktSent are low.
- R2: The control register is written whole and reads back as written. Its fields are: bits 1:0 modulation type (on modType), bit 2 deviation MSB (on devMsb), bit 3 inversion enable, bits 5:4 source select and bits 7:6 clock pin select.
- R3: With source select 00 and transmit on, txData follows gpioDataIn in the same cycle, with no register in between.
- R4: With source select 01 and transmit on, txData follows sdiPin in the same cycle while csN is high, and is held low while csN is low.
- R5: With the inversion enable bit set, the transmitted bit is the complement of the selected source bit.
- R6: With source select 10 and transmit on, each FIFO byte is sent MSB first, one bit per bitStrobe. A new byte is read, by a one-cycle fifoRdEn, only after the eighth bit of the previous byte, and never while fifoEmpty is high.
- R7: After the strobe of the last bit, when the FIFO is empty, pktSent is high for exactly one cycle and transmit-on clears in the same edge. The operating state then becomes tune (1) if PLL-on is set, or idle (0) if it is not. Transmit itself is state 2.
- R8: With source select 11, the bit sent is b8 of a 9-bit register. The register is seeded with all ones whenever transmit is off or another source is selected. On each bitStrobe while transmitting, it shifts toward b8 and takes b8 XOR b4 into b0, which realises x^9 + x^5 + 1.
- R9: The clock pin select picks the pulse output: 00 none, 01 clkGpio, 10 clkSdo (only while csN is high), 11 clkIrq. The chosen pin is high in every cycle where bitStrobe is high and transmit is on; the other pins stay low.
- R10: While transmit is off, txData and all clock pins are low, whatever the pins and the inversion bit do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Control register write strobe |
| cfgWrData | input | 8 | Control register write value |
| cfgRdData | output | 8 | Control register contents |
| devMsb | output | 1 | Deviation MSB field |
| modType | output | 2 | Modulation type field |
| opWrEn | input | 1 | Operating-mode write strobe |
| opWrTxOn | input | 1 | Transmit-on value to write |
| opWrPllOn | input | 1 | PLL-on value to write |
| txOn | output | 1 | Transmit-on bit |
| pllOn | output | 1 | PLL-on bit |
| opState | output | 2 | 0 idle, 1 tune, 2 transmit |
| bitStrobe | input | 1 | One pulse per modulation bit |
| fifoEmpty | input | 1 | FIFO holds no byte |
| fifoRdData | input | BYTE_W | Head byte of show-ahead FIFO |
| fifoRdEn | output | 1 | Pop the FIFO head |
| pktSent | output | 1 | One-cycle packet-sent pulse |
| gpioDataIn | input | 1 | Direct data from general-purpose pin |
| sdiPin | input | 1 | Direct data from serial data-in pin |
| csN | input | 1 | Serial chip select, active low |
| txData | output | 1 | Modulation bit to the modulator |
| clkGpio | output | 1 | Data clock on general-purpose pin |
| clkSdo | output | 1 | Data clock on serial data-out pin |
| clkIrq | output | 1 | Data clock on interrupt pin |

## Verification
Several properties are checked on every cycle: that at most one clock pin pulses, that the serial pins stay silent while chip select is low, that nothing leaves while transmit is off, that the PN9 register never reaches zero, that the FIFO is never popped when empty, and that the packet pulse lasts one cycle and coincides with transmit-on clearing. Some things only the bench scenarios can show. These are the actual bit order out of the FIFO, the exact PN9 sequence and its reseeding, the fall-back to tune versus idle, the register reset value, and the field decode. The bench runs a scoreboard of expected bits against the strobe-time samples to check them.

// File: rtl/txModPkg.sv
`timescale 1ns/1ps
package txModPkg;

  typedef enum logic [1:0] {
    SRC_GPIO = 2'b00,
    SRC_SDI  = 2'b01,
    SRC_FIFO = 2'b10,
    SRC_PN9  = 2'b11
  } srcSel_e;

  typedef enum logic [1:0] {
    CLK_NONE = 2'b00,
    CLK_GPIO = 2'b01,
    CLK_SDO  = 2'b10,
    CLK_IRQ  = 2'b11
  } clkSel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TUNE = 2'd1,
    ST_TX   = 2'd2
  } opState_e;

  // Control register image, MSB first
  typedef struct packed {
    clkSel_e    clkSel;
    srcSel_e    srcSel;
    logic       invEn;
    logic       devMsb;
    logic [1:0] modType;
  } cfgReg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic active;      // transmit on
    logic fifoLoaded;  // shift register holds a live byte
    logic loadByte;    // capture FIFO head
    logic shiftBit;    // advance within byte
    logic pnStep;      // advance PN9
    logic pnReseed;    // force PN9 seed
  } ctrlStrb_t;

endpackage

// File: rtl/tx_mod_ctrl.sv
`timescale 1ns/1ps
module tx_mod_ctrl
  import txModPkg::*;
#(
  parameter int         BYTE_W  = 8,
  parameter logic [7:0] CFG_RST = 8'h23
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [7:0] cfgWrData,
  input  logic       opWrEn,
  input  logic       opWrTxOn,
  input  logic       opWrPllOn,
  input  logic       bitStrobe,
  input  logic       fifoEmpty,
  output cfgReg_t    cfg,
  output logic       txOn,
  output logic       pllOn,
  output opState_e   opState,
  output logic       fifoRdEn,
  output logic       pktSent,
  output ctrlStrb_t  strb
);

  localparam int              CNT_W    = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic             loaded;
  logic [CNT_W-1:0] bitCnt;
  logic             fifoRun;
  logic             lastBit;
  logic             pktDone;
  logic             shiftBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cfg <= cfgReg_t'(CFG_RST);
    else if (cfgWrEn) cfg <= cfgReg_t'(cfgWrData);
  end

  assign fifoRun  = txOn && (cfg.srcSel == SRC_FIFO);
  assign lastBit  = fifoRun && loaded && bitStrobe && (bitCnt == LAST_BIT);
  assign pktDone  = lastBit && fifoEmpty;
  assign shiftBit = fifoRun && loaded && bitStrobe && (bitCnt != LAST_BIT);
  assign fifoRdEn = fifoRun && !fifoEmpty && (!loaded || lastBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loaded <= 1'b0;
      bitCnt <= '0;
    end else if (!fifoRun) begin
      loaded <= 1'b0;
      bitCnt <= '0;
    end else if (fifoRdEn) begin
      loaded <= 1'b1;
      bitCnt <= '0;
    end else if (pktDone) begin
      loaded <= 1'b0;
    end else if (shiftBit) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  // packet completion has priority over a coincident mode write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOn    <= 1'b0;
      pllOn   <= 1'b0;
      pktSent <= 1'b0;
    end else begin
      pktSent <= pktDone;
      if (pktDone)     txOn <= 1'b0;
      else if (opWrEn) txOn <= opWrTxOn;
      if (opWrEn)      pllOn <= opWrPllOn;
    end
  end

  always_comb begin
    if (txOn)       opState = ST_TX;
    else if (pllOn) opState = ST_TUNE;
    else            opState = ST_IDLE;
  end

  always_comb begin
    strb.active     = txOn;
    strb.fifoLoaded = loaded;
    strb.loadByte   = fifoRdEn;
    strb.shiftBit   = shiftBit;
    strb.pnStep     = txOn && (cfg.srcSel == SRC_PN9) && bitStrobe;
    strb.pnReseed   = !(txOn && (cfg.srcSel == SRC_PN9));
  end

  // R6
  fifo_rd_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoRdEn |-> !fifoEmpty);

  // R7
  pkt_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktSent |=> !pktSent);

  // R7
  pkt_txoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktSent |-> !txOn);

endmodule

// File: rtl/tx_mod_dp.sv
`timescale 1ns/1ps
module tx_mod_dp
  import txModPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PN_W   = 9,
  parameter int PN_TAP = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  srcSel_e           srcSel,
  input  clkSel_e           clkSel,
  input  logic              invEn,
  input  ctrlStrb_t         strb,
  input  logic              bitStrobe,
  input  logic [BYTE_W-1:0] fifoRdData,
  input  logic              gpioDataIn,
  input  logic              sdiPin,
  input  logic              csN,
  output logic              txData,
  output logic              clkGpio,
  output logic              clkSdo,
  output logic              clkIrq
);

  localparam logic [PN_W-1:0] PN_SEED = '1;
  localparam int              N_CLK   = 3;

  logic [BYTE_W-1:0] shReg;
  logic [PN_W-1:0]   lfsr;
  logic              rawBit;
  logic              srcOk;
  logic [N_CLK-1:0]  clkVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shReg <= '0;
    else if (strb.loadByte) shReg <= fifoRdData;
    else if (strb.shiftBit) shReg <= {shReg[BYTE_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lfsr <= PN_SEED;
    else if (strb.pnReseed) lfsr <= PN_SEED;
    else if (strb.pnStep)   lfsr <= {lfsr[PN_W-2:0], lfsr[PN_W-1] ^ lfsr[PN_TAP-1]};
  end

  always_comb begin
    unique case (srcSel)
      SRC_GPIO: begin rawBit = gpioDataIn;       srcOk = 1'b1;            end
      SRC_SDI:  begin rawBit = sdiPin;           srcOk = csN;             end
      SRC_FIFO: begin rawBit = shReg[BYTE_W-1];  srcOk = strb.fifoLoaded; end
      default:  begin rawBit = lfsr[PN_W-1];     srcOk = 1'b1;            end
    endcase
  end

  assign txData = strb.active && srcOk && (rawBit ^ invEn);

  // one pulse output per selectable pin; code g maps to clkVec[g-1]
  for (genvar g = 1; g <= N_CLK; g++) begin : gClkPin
    localparam logic [1:0] CODE = 2'(g);
    localparam bit         NEEDS_CS = (CODE == CLK_SDO);
    assign clkVec[g-1] = strb.active && bitStrobe && (clkSel == clkSel_e'(CODE))
                         && (!NEEDS_CS || csN);
  end

  assign clkGpio = clkVec[0];
  assign clkSdo  = clkVec[1];
  assign clkIrq  = clkVec[2];

  // R9
  clk_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({clkGpio, clkSdo, clkIrq}));

  // R9
  sdo_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> !clkSdo);

  // R4
  sdi_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == SRC_SDI && !csN) |-> !txData);

  // R8
  pn_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.active |-> (!txData && !clkGpio && !clkSdo && !clkIrq));

endmodule

// File: rtl/tx_mod_source.sv
`timescale 1ns/1ps
module tx_mod_source
  import txModPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  output logic              devMsb,
  output logic [1:0]        modType,
  input  logic              opWrEn,
  input  logic              opWrTxOn,
  input  logic              opWrPllOn,
  output logic              txOn,
  output logic              pllOn,
  output logic [1:0]        opState,
  input  logic              bitStrobe,
  input  logic              fifoEmpty,
  input  logic [BYTE_W-1:0] fifoRdData,
  output logic              fifoRdEn,
  output logic              pktSent,
  input  logic              gpioDataIn,
  input  logic              sdiPin,
  input  logic              csN,
  output logic              txData,
  output logic              clkGpio,
  output logic              clkSdo,
  output logic              clkIrq
);

  cfgReg_t   cfg;
  ctrlStrb_t strb;
  opState_e  stateQ;

  tx_mod_ctrl #(.BYTE_W(BYTE_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .opWrEn    (opWrEn),
    .opWrTxOn  (opWrTxOn),
    .opWrPllOn (opWrPllOn),
    .bitStrobe (bitStrobe),
    .fifoEmpty (fifoEmpty),
    .cfg       (cfg),
    .txOn      (txOn),
    .pllOn     (pllOn),
    .opState   (stateQ),
    .fifoRdEn  (fifoRdEn),
    .pktSent   (pktSent),
    .strb      (strb)
  );

  tx_mod_dp #(.BYTE_W(BYTE_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .srcSel     (cfg.srcSel),
    .clkSel     (cfg.clkSel),
    .invEn      (cfg.invEn),
    .strb       (strb),
    .bitStrobe  (bitStrobe),
    .fifoRdData (fifoRdData),
    .gpioDataIn (gpioDataIn),
    .sdiPin     (sdiPin),
    .csN        (csN),
    .txData     (txData),
    .clkGpio    (clkGpio),
    .clkSdo     (clkSdo),
    .clkIrq     (clkIrq)
  );

  assign cfgRdData = cfg;
  assign devMsb    = cfg.devMsb;
  assign modType   = cfg.modType;
  assign opState   = stateQ;

endmodule

// File: tb/tb_tx_mod_source.sv
`timescale 1ns/1ps
module tb_tx_mod_source;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic [7:0] cfgRdData;
  logic       devMsb;
  logic [1:0] modType;
  logic       opWrEn = 1'b0, opWrTxOn = 1'b0, opWrPllOn = 1'b0;
  logic       txOn, pllOn;
  logic [1:0] opState;
  logic       bitStrobe = 1'b0;
  logic       fifoEmpty;
  logic [7:0] fifoRdData;
  logic       fifoRdEn, pktSent;
  logic       gpioDataIn = 1'b0, sdiPin = 1'b0, csN = 1'b1;
  logic       txData, clkGpio, clkSdo, clkIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  tx_mod_source dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .devMsb(devMsb), .modType(modType),
    .opWrEn(opWrEn), .opWrTxOn(opWrTxOn), .opWrPllOn(opWrPllOn),
    .txOn(txOn), .pllOn(pllOn), .opState(opState), .bitStrobe(bitStrobe),
    .fifoEmpty(fifoEmpty), .fifoRdData(fifoRdData), .fifoRdEn(fifoRdEn),
    .pktSent(pktSent), .gpioDataIn(gpioDataIn), .sdiPin(sdiPin), .csN(csN),
    .txData(txData), .clkGpio(clkGpio), .clkSdo(clkSdo), .clkIrq(clkIrq)
  );

  // show-ahead FIFO model
  logic [7:0] fMem [16];
  int fRd = 0;
  int fWr = 0;
  int nReads = 0;
  assign fifoEmpty  = (fRd == fWr);
  assign fifoRdData = fMem[fRd[3:0]];
  always @(posedge clk) if (fifoRdEn) begin fRd <= fRd + 1; nReads <= nReads + 1; end

  // scoreboard
  bit    expQ[$];
  bit    monOn = 1'b0;
  string monTag = "R6";
  int    pktCycles = 0;
  logic [2:0] lastClk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (pktSent) pktCycles++;
    if (monOn && bitStrobe) begin
      if (expQ.size() == 0) chk({monTag, " unexpected bit"}, 32'(txData), 32'hEEEE);
      else begin
        bit e;
        e = expQ.pop_front();
        chk(monTag, 32'(txData), 32'(e));
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wrCfg(logic [7:0] v);
    cfgWrEn = 1'b1; cfgWrData = v; tick(); cfgWrEn = 1'b0;
  endtask

  task automatic wrOp(logic tx, logic pll);
    opWrEn = 1'b1; opWrTxOn = tx; opWrPllOn = pll; tick(); opWrEn = 1'b0;
  endtask

  task automatic strobe();
    bitStrobe = 1'b1;
    @(negedge clk);
    lastClk = {clkIrq, clkSdo, clkGpio};
    @(posedge clk); #1;
    bitStrobe = 1'b0;
    tick();
  endtask

  task automatic sendBytes(logic [7:0] b [], bit inv);
    foreach (b[i]) begin
      fMem[fWr[3:0]] = b[i];
      fWr++;
      for (int k = 7; k >= 0; k--) expQ.push_back(b[i][k] ^ inv);
    end
  endtask

  task automatic pushPn(int n, bit inv);
    logic [8:0] s;
    s = 9'h1FF;
    for (int i = 0; i < n; i++) begin
      expQ.push_back(s[8] ^ inv);
      s = {s[7:0], s[8] ^ s[4]};
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg", 32'(cfgRdData), 32'h23);
    chk("R1 txOn", 32'(txOn), 0);
    chk("R1 pllOn", 32'(pllOn), 0);
    chk("R1 state", 32'(opState), 0);
    chk("R1 outs", 32'({txData, clkGpio, clkSdo, clkIrq, fifoRdEn, pktSent}), 0);
    tick();

    // R2 field decode
    wrCfg(8'b1011_0110);
    @(negedge clk);
    chk("R2 readback", 32'(cfgRdData), 32'hB6);
    chk("R2 devMsb", 32'(devMsb), 1);
    chk("R2 modType", 32'(modType), 2);
    tick();

    // R10 idle: gpio source, gpio high, inversion on, transmit off
    wrCfg(8'h48);
    gpioDataIn = 1'b1;
    strobe();
    @(negedge clk);
    chk("R10 txData idle", 32'(txData), 0);
    chk("R10 clocks idle", 32'(lastClk), 0);
    tick();

    // R3 direct gpio, clock on gpio pin
    wrCfg(8'h40);
    wrOp(1'b1, 1'b0);
    gpioDataIn = 1'b1; @(negedge clk); chk("R3 gpio=1", 32'(txData), 1);
    @(posedge clk); #1;
    gpioDataIn = 1'b0; @(negedge clk); chk("R3 gpio=0", 32'(txData), 0);
    @(posedge clk); #1;
    strobe();
    chk("R9 clk on gpio", 32'(lastClk), 3'b001);
    chk("R7 state tx", 32'(opState), 2);

    // R5 inversion
    wrCfg(8'h48);
    gpioDataIn = 1'b1; @(negedge clk); chk("R5 inverted 1", 32'(txData), 0);
    @(posedge clk); #1;
    gpioDataIn = 1'b0; @(negedge clk); chk("R5 inverted 0", 32'(txData), 1);
    @(posedge clk); #1;

    // R4 sdi source, clock on sdo pin
    wrCfg(8'h90);
    csN = 1'b1; sdiPin = 1'b1;
    @(negedge clk); chk("R4 sdi cs high", 32'(txData), 1);
    @(posedge clk); #1;
    strobe();
    chk("R9 clk on sdo", 32'(lastClk), 3'b010);
    csN = 1'b0;
    @(negedge clk); chk("R4 sdi cs low", 32'(txData), 0);
    @(posedge clk); #1;
    strobe();
    chk("R9 sdo blocked", 32'(lastClk), 0);
    csN = 1'b1;

    // R9 irq pin and none
    wrCfg(8'hD0);
    strobe();
    chk("R9 clk on irq", 32'(lastClk), 3'b100);
    wrCfg(8'h10);
    strobe();
    chk("R9 no clock", 32'(lastClk), 0);
    chk("R7 no pkt in direct", 32'(pktCycles), 0);
    wrOp(1'b0, 1'b0);

    // R6/R7 FIFO packet, PLL on -> tune
    wrCfg(8'h20);
    sendBytes('{8'hA5, 8'h3C}, 1'b0);
    monTag = "R6 fifo bit";
    wrOp(1'b1, 1'b1);
    tick(3);
    monOn = 1'b1;
    for (int i = 0; i < 15; i++) strobe();
    chk("R7 no early pkt", 32'(pktCycles), 0);
    strobe();
    monOn = 1'b0;
    chk("R6 queue drained", 32'(expQ.size()), 0);
    chk("R6 reads", 32'(nReads), 2);
    chk("R7 pkt once", 32'(pktCycles), 1);
    chk("R7 tx cleared", 32'(txOn), 0);
    chk("R7 back to tune", 32'(opState), 1);

    // R5/R7 inverted FIFO packet, PLL off -> idle
    wrCfg(8'h28);
    sendBytes('{8'h96}, 1'b1);
    monTag = "R5 fifo inverted";
    wrOp(1'b1, 1'b0);
    tick(3);
    monOn = 1'b1;
    for (int i = 0; i < 8; i++) strobe();
    monOn = 1'b0;
    chk("R5 queue drained", 32'(expQ.size()), 0);
    chk("R7 pkt twice", 32'(pktCycles), 2);
    chk("R7 back to idle", 32'(opState), 0);

    // R8 PN9 sequence and reseed
    wrCfg(8'h30);
    pushPn(20, 1'b0);
    monTag = "R8 pn9 bit";
    wrOp(1'b1, 1'b0);
    tick(2);
    monOn = 1'b1;
    for (int i = 0; i < 20; i++) strobe();
    monOn = 1'b0;
    wrOp(1'b0, 1'b0);
    tick(2);
    pushPn(12, 1'b0);
    monTag = "R8 pn9 reseed";
    wrOp(1'b1, 1'b0);
    tick(2);
    monOn = 1'b1;
    for (int i = 0; i < 12; i++) strobe();
    monOn = 1'b0;
    chk("R8 queue drained", 32'(expQ.size()), 0);
    wrOp(1'b0, 1'b0);
    tick(2);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule